// File: doc/BRIEF.md
# Twelve-Line Interrupting GPIO Port

This block is a general-purpose port of twelve I/O lines behind a small synchronous register bus. Software picks a direction for each line and drives output values through a data register. It can arm each line to raise an interrupt on a rising edge, a falling edge, a high level or a low level. Pin inputs pass through a two-flop synchronizer. The synchronized values are also brought out raw, for neighbouring blocks that reuse a line for another function.

Lines 0 to 3 each have their own interrupt output. Lines 4 to 11 share one interrupt, and a flag register records which line fired. Any read of that flag register clears it. Event detection looks at the value the line actually carries. For a line set as an output, that is the driven value, so software can raise an interrupt from a data write. A line that no external source drives reads as 0, which models an internal pull-down.

Top module: `gpio_port`

## Requirements
- R1: At reset the direction register (address 0, bit n = line n, 1 = output) is all zero. `pad_oe` equals the direction register and follows a direction write on the next cycle.
- R2: A write to the data register (address 1) appears on `pad_out` on the next cycle. Only lines whose `pad_oe` bit is set are actually driven.
- R3: A read of address 1 returns the value each line carries: the driven data bit for output lines and the synchronized pin for input lines. An input whose `pad_drv` bit is 0 reads as 0. Read data appears on `bus_rdata` the cycle after `bus_rd` and is 0 when no read was made.
- R4: Edge mode is selected by mode register bit 0 (address 2). Polarity register bit 1 (address 3) detects a rising edge and bit 0 a falling edge. Each edge gives one event.
- R5: Level mode is selected by mode register bit 1. Polarity bit 1 means active high and 0 means active low. An event is produced on every cycle that the level holds.
- R6: `irq_ded[n]` for n in 0..3 is a registered copy of line n's event gated by bit n of the dedicated-enable register (address 4). A disabled line never asserts it.
- R7: An event on line n (4..11) with bit n-4 of the shared-enable register (address 5) set sets bit n-4 of the flag register (address 6, read-only). `irq_shared` is high while any flag bit is set.
- R8: A read of address 6 returns the flags and clears all of them. An enabled event in that same cycle leaves its own flag bit set.
- R9: A line set as an output with its interrupt armed raises the interrupt when a data write creates the qualifying edge or level.
- R10: Mode, polarity, data and both enable registers reset to zero, so no interrupt is armed after reset.
- R11: A pin change shows on `alt_tap` two cycles after it is applied. Detection uses that synchronized value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 12 | Write data |
| bus_rdata | output | 12 | Read data, one cycle after the strobe |
| pad_in | input | 12 | Level seen at each pad |
| pad_drv | input | 12 | 1 where an external source drives the pad |
| pad_out | output | 12 | Output value per line |
| pad_oe | output | 12 | Output enable per line |
| alt_tap | output | 12 | Synchronized pin values for alternate functions |
| irq_ded | output | 4 | Dedicated interrupts of lines 0 to 3 |
| irq_shared | output | 1 | Combined interrupt of lines 4 to 11 |

## Verification
Several rules are checked by assertions on every cycle. A direction write lands on `pad_oe`. Each dedicated interrupt is backed by an enabled event one cycle earlier. A rise of the shared interrupt is traced to an enabled event. A flag read with no new event leaves the flags empty. An edge-mode event always coincides with a change of the line. Other behaviours only show in the bench's scenarios. These are the exact pulse count per edge, a level interrupt that stays up, the flag bit that survives a read in the same cycle as a level event, the pull-down of undriven inputs, the two-cycle synchronizer latency, and an interrupt raised by the block's own data write. The bench's reference model is also compared against every output on every clock.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
    localparam int NLINES = 12;
    localparam int NDED   = 4;
    localparam int NSH    = NLINES - NDED;
    localparam int AW     = 3;

    typedef enum logic [AW-1:0] {
        REG_DIR   = 3'd0,
        REG_DATA  = 3'd1,
        REG_MODE  = 3'd2,
        REG_POL   = 3'd3,
        REG_DEDEN = 3'd4,
        REG_SHEN  = 3'd5,
        REG_FLAG  = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic [NLINES-1:0] dir;
        logic [NLINES-1:0] data;
        logic [NLINES-1:0] mode;   // 1 = level, 0 = edge
        logic [NLINES-1:0] pol;    // 1 = high/rising, 0 = low/falling
        logic [NDED-1:0]   ded_en;
        logic [NSH-1:0]    sh_en;
    } cfg_t;

    function automatic logic line_event(input logic lvl_mode, input logic pol,
                                        input logic cur, input logic prev);
        if (lvl_mode) return (cur == pol);
        if (pol)      return cur & ~prev;
        return ~cur & prev;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= din;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[k] <= '0;
            else     chain[k] <= chain[k-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
`timescale 1ns/1ps
module gpio_detect
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  logic [NLINES-1:0] pin_sync,
    output logic [NLINES-1:0] line_val,
    output logic [NLINES-1:0] evt
);
    logic [NLINES-1:0] prev_q;

    // an output line is observed through the value it drives
    assign line_val = (cfg.dir & cfg.data) | (~cfg.dir & pin_sync);

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= line_val;
    end

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        assign evt[i] = line_event(cfg.mode[i], cfg.pol[i], line_val[i], prev_q[i]);

        // R4: an edge-mode event only occurs where the line changed
        a_r4_edge_needs_change: assert property (@(posedge clk) disable iff (rst)
            (!cfg.mode[i] && evt[i]) |-> (line_val[i] != $past(line_val[i])));
    end
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [NLINES-1:0] bus_wdata,
    output logic [NLINES-1:0] bus_rdata,
    input  logic [NLINES-1:0] line_val,
    input  logic [NLINES-1:0] evt,
    output cfg_t              cfg,
    output logic [NDED-1:0]   irq_ded,
    output logic              irq_shared
);
    cfg_t              cfg_q;
    logic [NSH-1:0]    flag_q;
    logic [NDED-1:0]   ded_q;
    logic [NLINES-1:0] rdata_q;
    logic [NLINES-1:0] rd_mux;
    logic [NSH-1:0]    sh_hit;
    logic              flag_rd;
    reg_sel_e          sel;

    assign sel     = reg_sel_e'(bus_addr);
    assign flag_rd = bus_rd && (sel == REG_FLAG);
    assign sh_hit  = evt[NLINES-1:NDED] & cfg_q.sh_en;

    always_comb begin
        rd_mux = '0;
        case (sel)
            REG_DIR:   rd_mux = cfg_q.dir;
            REG_DATA:  rd_mux = line_val;
            REG_MODE:  rd_mux = cfg_q.mode;
            REG_POL:   rd_mux = cfg_q.pol;
            REG_DEDEN: rd_mux[NDED-1:0] = cfg_q.ded_en;
            REG_SHEN:  rd_mux[NSH-1:0]  = cfg_q.sh_en;
            REG_FLAG:  rd_mux[NSH-1:0]  = flag_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (bus_wr) begin
            case (sel)
                REG_DIR:   cfg_q.dir    <= bus_wdata;
                REG_DATA:  cfg_q.data   <= bus_wdata;
                REG_MODE:  cfg_q.mode   <= bus_wdata;
                REG_POL:   cfg_q.pol    <= bus_wdata;
                REG_DEDEN: cfg_q.ded_en <= bus_wdata[NDED-1:0];
                REG_SHEN:  cfg_q.sh_en  <= bus_wdata[NSH-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= '0;
            ded_q   <= '0;
            rdata_q <= '0;
        end else begin
            // a new event wins over the clear of the same cycle
            flag_q  <= (flag_rd ? '0 : flag_q) | sh_hit;
            ded_q   <= evt[NDED-1:0] & cfg_q.ded_en;
            rdata_q <= bus_rd ? rd_mux : '0;
        end
    end

    assign cfg        = cfg_q;
    assign irq_ded    = ded_q;
    assign irq_shared = |flag_q;
    assign bus_rdata  = rdata_q;

    a_r1_dir_write_lands: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == REG_DIR) |=> (cfg_q.dir == $past(bus_wdata)));

    a_r6_ded_needs_enabled_event: assert property (@(posedge clk) disable iff (rst)
        (ded_q & ~$past(evt[NDED-1:0] & cfg_q.ded_en)) == '0);

    a_r7_shared_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_shared) |-> $past(|sh_hit));

    a_r8_read_empties_flags: assert property (@(posedge clk) disable iff (rst)
        (flag_rd && sh_hit == '0) |=> (flag_q == '0));
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [NLINES-1:0] bus_wdata,
    output logic [NLINES-1:0] bus_rdata,
    input  logic [NLINES-1:0] pad_in,
    input  logic [NLINES-1:0] pad_drv,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe,
    output logic [NLINES-1:0] alt_tap,
    output logic [NDED-1:0]   irq_ded,
    output logic              irq_shared
);
    cfg_t              cfg;
    logic [NLINES-1:0] pin_raw;
    logic [NLINES-1:0] pin_sync;
    logic [NLINES-1:0] line_val;
    logic [NLINES-1:0] evt;

    // undriven pads are pulled low
    assign pin_raw = pad_in & pad_drv;

    gpio_sync #(.W(NLINES), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din(pin_raw), .dout(pin_sync)
    );

    gpio_detect u_detect (
        .clk(clk), .rst(rst), .cfg(cfg), .pin_sync(pin_sync),
        .line_val(line_val), .evt(evt)
    );

    gpio_regs u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_val(line_val), .evt(evt), .cfg(cfg),
        .irq_ded(irq_ded), .irq_shared(irq_shared)
    );

    assign pad_out = cfg.data;
    assign pad_oe  = cfg.dir;
    assign alt_tap = pin_sync;
endmodule

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [11:0] bus_wdata = '0;
    logic [11:0] bus_rdata;
    logic [11:0] pad_in = '0, pad_drv = '0;
    logic [11:0] pad_out, pad_oe, alt_tap;
    logic [3:0]  irq_ded;
    logic        irq_shared;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;

    always #10 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_drv(pad_drv), .pad_out(pad_out), .pad_oe(pad_oe),
        .alt_tap(alt_tap), .irq_ded(irq_ded), .irq_shared(irq_shared)
    );

    task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [11:0] m_dir, m_data, m_mode, m_pol, m_s1, m_s2, m_prev, m_rdata;
    logic [3:0]  m_ded_en, m_irq;
    logic [7:0]  m_sh_en, m_flag;

    always @(posedge clk) begin
        logic [11:0] lv, ev, val;
        if (rst) begin
            m_dir = 0; m_data = 0; m_mode = 0; m_pol = 0; m_s1 = 0; m_s2 = 0;
            m_prev = 0; m_rdata = 0; m_ded_en = 0; m_irq = 0; m_sh_en = 0; m_flag = 0;
        end else begin
            for (int i = 0; i < 12; i++) begin
                lv[i] = m_dir[i] ? m_data[i] : m_s2[i];
                if (m_mode[i])     ev[i] = (lv[i] == m_pol[i]);
                else if (m_pol[i]) ev[i] = lv[i] && !m_prev[i];
                else               ev[i] = !lv[i] && m_prev[i];
            end
            case (bus_addr)
                3'd0: val = m_dir;
                3'd1: val = lv;
                3'd2: val = m_mode;
                3'd3: val = m_pol;
                3'd4: val = {8'h0, m_ded_en};
                3'd5: val = {4'h0, m_sh_en};
                3'd6: val = {4'h0, m_flag};
                default: val = 0;
            endcase
            m_rdata = bus_rd ? val : 12'h0;
            m_irq   = ev[3:0] & m_ded_en;
            m_flag  = ((bus_rd && bus_addr == 3'd6) ? 8'h0 : m_flag) | (ev[11:4] & m_sh_en);
            m_prev  = lv;
            m_s2    = m_s1;
            m_s1    = pad_in & pad_drv;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_dir = bus_wdata;
                    3'd1: m_data = bus_wdata;
                    3'd2: m_mode = bus_wdata;
                    3'd3: m_pol = bus_wdata;
                    3'd4: m_ded_en = bus_wdata[3:0];
                    3'd5: m_sh_en = bus_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R1 pad_oe model", pad_oe, m_dir);
            check("R2 pad_out model", pad_out, m_data);
            check("R3 bus_rdata model", bus_rdata, m_rdata);
            check("R11 alt_tap model", alt_tap, m_s2);
            check("R6 irq_ded model", {8'h0, irq_ded}, {8'h0, m_irq});
            check("R7 irq_shared model", {11'h0, irq_shared}, {11'h0, |m_flag});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [11:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [11:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // count cycles in which irq_ded[b] is high over n cycles
    task automatic count_ded(input int b, input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (irq_ded[b]) c++;
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] d;
        int c0, c1;
        repeat (3) @(negedge clk);
        rst = 0;
        cmp_on = 1;

        // R1 / R10 reset state
        rd(3'd0, d); check("R1 dir reset", d, 12'h000);
        check("R1 pad_oe reset", pad_oe, 12'h000);
        rd(3'd4, d); check("R10 dedicated enable reset", d, 12'h000);
        rd(3'd5, d); check("R10 shared enable reset", d, 12'h000);
        rd(3'd2, d); check("R10 mode reset", d, 12'h000);

        // R3 pull-down on undriven inputs
        pad_in = 12'hFFF; pad_drv = 12'h000; idle(4);
        rd(3'd1, d); check("R3 undriven reads 0", d, 12'h000);
        pad_drv = 12'h00F; idle(4);
        rd(3'd1, d); check("R3 driven inputs read", d, 12'h00F);

        // R11 synchronizer latency
        pad_drv = 12'hFFF; pad_in = 12'h000; idle(4);
        @(negedge clk); pad_in = 12'h080;
        @(negedge clk); check("R11 tap not yet", alt_tap & 12'h080, 12'h000);
        @(negedge clk); check("R11 tap after two", alt_tap & 12'h080, 12'h080);

        // R2 outputs and mixed read
        wr(3'd0, 12'hF00); wr(3'd1, 12'hA5A);
        check("R2 pad_out", pad_out, 12'hA5A);
        check("R1 pad_oe", pad_oe, 12'hF00);
        rd(3'd1, d); check("R3 mixed read", d, 12'hA80);
        wr(3'd0, 12'h000); wr(3'd1, 12'h000);

        // R4 / R6 edge mode on dedicated lines
        pad_in = 12'h002; idle(4);
        wr(3'd2, 12'h000); wr(3'd3, 12'h001); wr(3'd4, 12'h003); idle(2);
        pad_in = 12'h001;
        fork
            count_ded(0, 6, c0);
            count_ded(1, 6, c1);
        join
        check("R4 rising pulse line0", 12'(c0), 12'd1);
        check("R4 falling pulse line1", 12'(c1), 12'd1);
        wr(3'd4, 12'h001); pad_in = 12'h002;
        fork
            count_ded(0, 6, c0);
            count_ded(1, 6, c1);
        join
        check("R4 wrong edges ignored line0", 12'(c0), 12'd0);
        check("R4 wrong edges ignored line1", 12'(c1), 12'd0);
        pad_in = 12'h001;
        fork
            count_ded(0, 6, c0);
            count_ded(1, 6, c1);
        join
        check("R6 enabled line0 fires", 12'(c0), 12'd1);
        check("R6 disabled line1 silent", 12'(c1), 12'd0);

        // R5 level mode, active low on line 2
        wr(3'd2, 12'h004); wr(3'd3, 12'h000); wr(3'd4, 12'h004); idle(2);
        count_ded(2, 5, c0);
        check("R5 active low held", 12'(c0), 12'd5);
        pad_in = 12'h005; idle(4);
        check("R5 level released", {11'h0, irq_ded[2]}, 12'h000);

        // R7 / R8 shared edge on line 5
        wr(3'd4, 12'h000); wr(3'd2, 12'h000); wr(3'd3, 12'h060);
        wr(3'd5, 12'h002); idle(2);
        rd(3'd6, d);
        pad_in = 12'h065; idle(5);
        check("R7 shared raised", {11'h0, irq_shared}, 12'h001);
        rd(3'd6, d); check("R7 flag bit line5 only", d, 12'h002);
        check("R8 shared cleared by read", {11'h0, irq_shared}, 12'h000);
        rd(3'd6, d); check("R8 flags empty", d, 12'h000);

        // R8 / R5 read in the same cycle as a level event on line 6
        pad_in = 12'h025; idle(4);
        wr(3'd2, 12'h040); wr(3'd3, 12'h040); wr(3'd5, 12'h004);
        pad_in = 12'h065; idle(4);
        rd(3'd6, d); check("R8 level flag read", d, 12'h004);
        check("R8 flag survives read", {11'h0, irq_shared}, 12'h001);
        pad_in = 12'h025; idle(4);
        rd(3'd6, d); check("R5 last level flag", d, 12'h004);
        rd(3'd6, d); check("R8 empty after level gone", d, 12'h000);

        // R9 interrupt from own data write on line 3
        wr(3'd5, 12'h000); wr(3'd2, 12'h000); wr(3'd3, 12'h008);
        wr(3'd0, 12'h008); wr(3'd4, 12'h008); idle(3);
        @(negedge clk); bus_wr = 1; bus_addr = 3'd1; bus_wdata = 12'h008;
        @(negedge clk); bus_wr = 0;
        count_ded(3, 5, c0);
        check("R9 output write fires", 12'(c0), 12'd1);

        idle(3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule